// File: doc/BRIEF.md
# Serial link start-up controller

This block brings up one point-to-point serial link that runs over a word-aligned transceiver. A build-time parameter makes it either the master end or the slave end of the link. It drives the transceiver's transmit enable and receive reset. It watches the receiver's recovered-clock and word-alignment status, together with the decoded incoming words. It chooses which of two idle words the local transmitter sends, and it raises a link-active flag once bring-up is complete.

The master enables its transmitter straight away and waits for the partner. The slave waits for a recovered clock. It then resets its receiver repeatedly until word alignment locks, and holds its local logic in reset for that whole time. Readiness is signalled by a change of idle word. The slave switches from the first idle to the second once it is aligned. The master, after it locks and sees the second idle, waits a settling delay, then goes active and switches its own idle. The slave goes active when it receives the master's second idle.

In systems with a single central master, the idle-change handshake can be switched off by a parameter. All delays are clock-cycle counts set by parameters, so that they can be shortened for simulation.

Top module: `link_bringup_ctrl`

## Requirements
- R1: Directly after reset, `link_up` is 0 and `tx_idle_d` is 0xC5, which is the first idle variant; the idle K code is 0xBC. The slave holds `tx_en` at 0, and holds `local_rst` and `rx_rst` at 1. The master drives `tx_en` at 1 and `local_rst` at 0.
- R2: While the master is waiting, any incoming traffic other than a valid word with K 0xBC and data 0x50 leaves `link_up` at 0 and `tx_idle_d` at 0xC5. This includes the first idle variant (K 0xBC, data 0xC5).
- R3: The master's settling delay starts on the clock edge at which it is locked (`rx_clk_ok` and `rx_aligned` both high) and receives a valid second idle. `link_up` rises, and `tx_idle_d` becomes 0x50, exactly SETTLE_CYCLES edges later.
- R4: If lock is lost during the master's settling delay, the delay is abandoned. `link_up` does not rise until a fresh second idle is received and a complete delay has run.
- R5: While the slave is in its alignment hunt, `rx_rst` is high for one cycle at the start of each try, and tries repeat every TRY_CYCLES cycles.
- R6: On the edge where the slave sees alignment, it releases `local_rst`, sets `tx_en`, and switches `tx_idle_d` to 0x50. `rx_rst` is only ever high while `local_rst` is high.
- R7: A slave that is aligned and sending the second idle goes active on the edge after it receives a valid word with K 0xBC and data 0x50. Words carrying the first idle do not make it active.
- R8: A valid received word with K code 0xFE, in any state, returns the controller to its initial state on the next edge. `link_up` drops and `tx_idle_d` returns to 0xC5.
- R9: When `link_up` is high and lock is lost, `link_up` is 0 after the next edge, `tx_idle_d` is 0xC5, and a slave again asserts `local_rst`.
- R10: With HANDSHAKE=0, a slave goes active on the edge after alignment, without waiting for any idle word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk_ok | input | 1 | Receiver has a recovered clock |
| rx_aligned | input | 1 | Receiver word alignment locked at bit 0 |
| rx_vld | input | 1 | A decoded control word is present on rx_k/rx_d |
| rx_k | input | 8 | Received comma (K) byte |
| rx_d | input | 8 | Received data byte following the comma |
| tx_en | output | 1 | Transmitter enable |
| rx_rst | output | 1 | Receiver reset request |
| local_rst | output | 1 | Hold for logic that runs on the recovered clock |
| tx_idle_d | output | 8 | Data byte of the idle word to transmit (0xC5 or 0x50) |
| link_up | output | 1 | Link declared active |

## Verification
Two events can fall in the same cycle. One is a loss of lock or a link-reset word. The other is a step forward in the start-up sequence, such as the second idle arriving at the master or the end of a slave alignment try. The bench provokes this by dropping alignment partway through the master's settling delay. It also sends a reset word while the link is already active. In both cases it requires the result to be the initial state, with no late rise of `link_up`. Random traffic that avoids the second idle and the reset code is sent to a locked, waiting master to show that nothing else moves it forward.

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl #(
  parameter bit IS_MASTER     = 1'b1,
  parameter bit HANDSHAKE     = 1'b1,
  parameter int TRY_CYCLES    = 500000,
  parameter int SETTLE_CYCLES = 62500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_clk_ok,
  input  logic       rx_aligned,
  input  logic       rx_vld,
  input  logic [7:0] rx_k,
  input  logic [7:0] rx_d,
  output logic       tx_en,
  output logic       rx_rst,
  output logic       local_rst,
  output logic [7:0] tx_idle_d,
  output logic       link_up
);
  localparam int         SPAN  = IS_MASTER ? SETTLE_CYCLES : TRY_CYCLES;
  localparam int         CW    = $clog2(SPAN + 1);
  localparam logic [7:0] K_IDL = 8'hBC;
  localparam logic [7:0] K_RST = 8'hFE;
  localparam logic [7:0] D_ID1 = 8'hC5;
  localparam logic [7:0] D_ID2 = 8'h50;

  typedef enum logic [2:0] {ST_START, ST_HUNT, ST_SETTLE, ST_READY, ST_ACTIVE} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  wire locked  = rx_clk_ok & rx_aligned;
  wire rst_req = rx_vld & (rx_k == K_RST);
  wire idle2   = rx_vld & (rx_k == K_IDL) & (rx_d == D_ID2);
  wire cnt_end = (cnt == CW'(SPAN - 1));

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (rst_req) begin
      st_nx  = ST_START;
      cnt_nx = '0;
    end else begin
      unique case (st)
        ST_START:
          if (IS_MASTER) begin
            if (locked && (idle2 || !HANDSHAKE)) begin
              st_nx  = ST_SETTLE;
              cnt_nx = '0;
            end
          end else if (rx_clk_ok) begin
            st_nx  = ST_HUNT;
            cnt_nx = '0;
          end
        ST_HUNT:
          if (!rx_clk_ok)      st_nx = ST_START;
          else if (rx_aligned) st_nx = HANDSHAKE ? ST_READY : ST_ACTIVE;
          else                 cnt_nx = cnt_end ? '0 : cnt + 1'b1;
        ST_SETTLE:
          if (!locked)      st_nx = ST_START;
          else if (cnt_end) st_nx = ST_ACTIVE;
          else              cnt_nx = cnt + 1'b1;
        ST_READY:
          if (!locked)    st_nx = ST_START;
          else if (idle2) st_nx = ST_ACTIVE;
        ST_ACTIVE:
          if (!locked) st_nx = ST_START;
        default: st_nx = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_START;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign link_up   = (st == ST_ACTIVE);
  assign tx_en     = IS_MASTER ? 1'b1 : (st == ST_READY || st == ST_ACTIVE);
  assign local_rst = !IS_MASTER && (st == ST_START || st == ST_HUNT);
  assign rx_rst    = !IS_MASTER && (st == ST_START || (st == ST_HUNT && cnt == '0));
  assign tx_idle_d = (st == ST_ACTIVE || st == ST_READY) ? D_ID2 : D_ID1;
endmodule

// File: rtl/link_bringup_ctrl_chk.sv
module link_bringup_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_clk_ok,
  input logic       rx_aligned,
  input logic       rx_vld,
  input logic [7:0] rx_k,
  input logic       tx_en,
  input logic       rx_rst,
  input logic       local_rst,
  input logic [7:0] tx_idle_d,
  input logic       link_up
);
  p_held_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    local_rst |-> (!tx_en && !link_up));

  p_rise_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(rx_clk_ok && rx_aligned));

  p_rxrst_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> local_rst);

  p_reset_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_k == 8'hFE) |=> (!link_up && tx_idle_d == 8'hC5));

  p_lock_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !(rx_clk_ok && rx_aligned)) |=> (!link_up && tx_idle_d == 8'hC5));

  p_active_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (tx_en && tx_idle_d == 8'h50));
endmodule

bind link_bringup_ctrl link_bringup_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_clk_ok(rx_clk_ok), .rx_aligned(rx_aligned),
  .rx_vld(rx_vld), .rx_k(rx_k), .tx_en(tx_en), .rx_rst(rx_rst),
  .local_rst(local_rst), .tx_idle_d(tx_idle_d), .link_up(link_up)
);

// File: tb/link_bringup_ctrl_bench.sv
`timescale 1ns/1ps
module link_bringup_ctrl_bench;
  localparam int TRY = 8;
  localparam int SET = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic       m_ok = 0, m_al = 0, m_v = 0;
  logic [7:0] m_k = 0, m_d = 0;
  logic       m_tx, m_rr, m_lr, m_up;
  logic [7:0] m_id;

  logic       s_ok = 0, s_al = 0, s_v = 0;
  logic [7:0] s_k = 0, s_d = 0;
  logic       s_tx, s_rr, s_lr, s_up;
  logic [7:0] s_id;

  logic       b_ok = 0, b_al = 0;
  logic       b_tx, b_rr, b_lr, b_up;
  logic [7:0] b_id;

  link_bringup_ctrl #(.IS_MASTER(1'b1), .HANDSHAKE(1'b1), .TRY_CYCLES(TRY), .SETTLE_CYCLES(SET))
    u_link_bringup_ctrl (.clk(clk), .rst_n(rst_n), .rx_clk_ok(m_ok), .rx_aligned(m_al),
      .rx_vld(m_v), .rx_k(m_k), .rx_d(m_d), .tx_en(m_tx), .rx_rst(m_rr),
      .local_rst(m_lr), .tx_idle_d(m_id), .link_up(m_up));

  link_bringup_ctrl #(.IS_MASTER(1'b0), .HANDSHAKE(1'b1), .TRY_CYCLES(TRY), .SETTLE_CYCLES(SET))
    u_slv (.clk(clk), .rst_n(rst_n), .rx_clk_ok(s_ok), .rx_aligned(s_al),
      .rx_vld(s_v), .rx_k(s_k), .rx_d(s_d), .tx_en(s_tx), .rx_rst(s_rr),
      .local_rst(s_lr), .tx_idle_d(s_id), .link_up(s_up));

  link_bringup_ctrl #(.IS_MASTER(1'b0), .HANDSHAKE(1'b0), .TRY_CYCLES(TRY), .SETTLE_CYCLES(SET))
    u_byp (.clk(clk), .rst_n(rst_n), .rx_clk_ok(b_ok), .rx_aligned(b_al),
      .rx_vld(1'b0), .rx_k(8'h00), .rx_d(8'h00), .tx_en(b_tx), .rx_rst(b_rr),
      .local_rst(b_lr), .tx_idle_d(b_id), .link_up(b_up));

  function automatic logic [7:0] exp_idle(input bit second);
    return second ? 8'h50 : 8'hC5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    int pulses;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 m_up", m_up, 0);   chk("R1 m_idle", m_id, exp_idle(0));
    chk("R1 m_tx", m_tx, 1);   chk("R1 m_lr", m_lr, 0);
    chk("R1 s_tx", s_tx, 0);   chk("R1 s_lr", s_lr, 1);
    chk("R1 s_rr", s_rr, 1);   chk("R1 s_idle", s_id, exp_idle(0));

    // R2 random traffic to a locked master, never second idle nor reset word
    m_ok = 1; m_al = 1;
    for (int i = 0; i < 60; i++) begin
      m_v = 1'($urandom);
      case ($urandom % 4)
        0: m_k = 8'hBC;
        1: m_k = 8'h1C;
        2: m_k = 8'hFB;
        default: m_k = 8'($urandom);
      endcase
      if (m_k == 8'hFE) m_k = 8'h7C;
      m_d = 8'($urandom);
      if (m_k == 8'hBC && m_d == 8'h50) m_d = 8'hC5;
      nclk(1);
      chk("R2 m_up random", m_up, 0);
    end
    chk("R2 m_idle", m_id, exp_idle(0));

    // R3 exact settling delay
    m_v = 1; m_k = 8'hBC; m_d = 8'h50;
    nclk(1);
    m_d = 8'hC5;
    nclk(SET - 1);
    chk("R3 m_up early", m_up, 0);
    nclk(1);
    chk("R3 m_up on time", m_up, 1);
    chk("R3 m_idle", m_id, exp_idle(1));

    // R9 loss of lock on active master
    m_al = 0;
    nclk(1);
    chk("R9 m_up", m_up, 0);
    chk("R9 m_idle", m_id, exp_idle(0));

    // R4 lock lost during settling, same cycle as counting
    m_al = 1; m_d = 8'h50;
    nclk(1);
    m_d = 8'hC5;
    nclk(5);
    m_al = 0;
    nclk(1);
    m_al = 1;
    nclk(SET + 2);
    chk("R4 m_up abandoned", m_up, 0);

    // R8 reset word on active master
    m_d = 8'h50;
    nclk(SET + 1);
    chk("R8 m_up before", m_up, 1);
    m_k = 8'hFE; m_d = 8'h00;
    nclk(1);
    chk("R8 m_up", m_up, 0);
    chk("R8 m_idle", m_id, exp_idle(0));
    m_k = 8'hBC; m_d = 8'hC5;

    // Slave: R1 hold without recovered clock
    nclk(5);
    chk("R1 s_tx no clk", s_tx, 0);
    chk("R1 s_lr no clk", s_lr, 1);
    // R5 alignment retries
    s_ok = 1;
    nclk(1);
    pulses = 0;
    for (int t = 1; t <= 3 * TRY; t++) begin
      nclk(1);
      if (s_rr) pulses++;
      if (t == TRY - 1) chk("R5 rr between tries", s_rr, 0);
      if (t == TRY)     chk("R5 rr new try", s_rr, 1);
    end
    chk("R5 pulse count", pulses, 3);
    chk("R6 s_lr hunting", s_lr, 1);

    // R6 alignment
    s_al = 1;
    nclk(1);
    chk("R6 s_lr", s_lr, 0);  chk("R6 s_tx", s_tx, 1);
    chk("R6 s_idle", s_id, exp_idle(1)); chk("R6 s_rr", s_rr, 0);
    chk("R7 s_up not yet", s_up, 0);

    // R7 first idle ignored, second idle activates
    s_v = 1; s_k = 8'hBC; s_d = 8'hC5;
    nclk(5);
    chk("R7 s_up first idle", s_up, 0);
    s_d = 8'h50;
    nclk(1);
    chk("R7 s_up", s_up, 1);

    // R9 slave lock loss
    s_al = 0;
    nclk(1);
    chk("R9 s_up", s_up, 0);
    chk("R9 s_lr", s_lr, 1);
    chk("R9 s_idle", s_id, exp_idle(0));
    s_al = 1;
    nclk(4);
    chk("R7 s_up relink", s_up, 1);

    // R8 reset word on active slave
    s_k = 8'hFE;
    nclk(1);
    chk("R8 s_up", s_up, 0);
    chk("R8 s_idle", s_id, exp_idle(0));
    s_k = 8'hBC; s_d = 8'hC5;

    // R10 bypass slave
    b_ok = 1; b_al = 1;
    nclk(1);
    chk("R10 b_up hunt", b_up, 0);
    nclk(1);
    chk("R10 b_up", b_up, 1);
    chk("R10 b_tx", b_tx, 1);
    chk("R10 b_lr", b_lr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule